// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides, from the 48-bit destination address at the head of each received frame, whether the frame should be kept or thrown away. The receive framer hands it the address one byte per clock, with a strobe for each valid byte and a separate mark on the first byte of a frame. Once the sixth byte has been taken, the block presents a registered match indication that says which rule matched. When the framer later signals the end of the frame, the block gives its final keep/drop verdict. An external veto input is sampled at that point.

Three filtering modes are offered. The individual-only mode matches unicast addresses against one programmed station address, or against a 64-bin hash table. The logical mode also admits group addresses, through a second 64-bin hash table, and admits the all-ones broadcast address unless broadcast is switched off. The promiscuous mode admits every address, but the external veto still wins. Hash bins are selected by six bits of a CRC-32 computed over the six address bytes.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset, match_valid, dec_valid and accept are 0 and match_type is 0 (no match).
- R2: byte_sof marks byte 0 of a frame. The first six bytes taken with byte_valid (byte 0 first) form the address. Address bit 8*i+j is bit j of byte i, and bit j is transmitted before bit j+1. match_valid is a one-cycle pulse in the cycle after byte 5 is taken. Bytes after the sixth, and bytes that follow a frame end without a new byte_sof, change nothing.
- R3: match_type codes are 0 none, 1 station exact, 2 individual hash, 3 group hash, 4 broadcast and 5 promiscuous. The code is held until the next match_valid. A frame can be kept only if its code is not 0.
- R4: An address whose byte 0 bit 0 is 1 is a group address. Otherwise it is individual.
- R5: mode 0 (individual only) with use_hash 0: an individual address gets code 1 if it equals station_addr (same byte order as R2), else 0. A group address always gets 0 in mode 0.
- R6: mode 0 with use_hash 1: an individual address gets code 2 if bit idx of ind_hash is 1, else 0.
- R7: idx is bits 31:26 of a CRC register that starts at all ones and is updated LSB-first with the reflected polynomial 0xEDB88320 over the six bytes, with no final inversion.
- R8: mode 1 (logical): individual addresses follow R5/R6. The all-ones address gets code 4 when bcast_en is 1 and 0 when it is 0, and never consults a table. Any other group address gets code 3 if bit idx of grp_hash is 1, else 0.
- R9: mode 2 (promiscuous) gives code 5 for every address. mode 3 gives code 0 for every address.
- R10: dec_valid is a one-cycle pulse in the cycle after frame_end. accept is 1 only if all six address bytes were taken before the frame_end cycle, the code is not 0, and reject is 0 in the frame_end cycle.
- R11: A frame that ends before its match_valid has been presented is discarded, and no match_valid appears for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | A received byte is present on byte_data |
| byte_sof | input | 1 | The present byte is byte 0 of a new frame |
| byte_data | input | 8 | Received byte |
| frame_end | input | 1 | The current frame has ended (one-cycle pulse) |
| reject | input | 1 | External veto, sampled with frame_end |
| mode | input | 2 | 0 individual only, 1 logical, 2 promiscuous, 3 drop all |
| ind_use_hash | input | 1 | Individual addresses use the hash table instead of the station address |
| bcast_en | input | 1 | Broadcast admitted in logical mode |
| station_addr | input | 48 | Programmed station address |
| ind_hash | input | 64 | Individual-address bin table |
| grp_hash | input | 64 | Group-address bin table |
| match_valid | output | 1 | Match indication valid (one-cycle pulse) |
| match_type | output | 3 | Matched rule code |
| dec_valid | output | 1 | Final verdict valid (one-cycle pulse) |
| accept | output | 1 | Keep the frame (1) or discard it (0) |

## Verification
The bench computes each hash bin with a left-shifting normal-form CRC and then bit-reverses the result. This catches a design that uses the wrong end of the CRC register, or feeds address bits MSB first, because such a design lands in a different bin. Each hash test is paired with a table that sets every bin except the expected one, so a design that ignores the table, or reads a neighbouring bin, keeps a frame it should drop. Broadcast is tried with the group table fully set and bcast_en off, which exposes a design that lets the all-ones address fall through to the hash. Two further cases cover frames that end after three bytes, and bytes that arrive after a frame end with no start mark. A design that completes a stale address in either case would pulse match_valid or keep the frame.

// File: rtl/eth_af_pkg.sv
package eth_af_pkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;

  typedef enum logic [2:0] {
    MT_NONE     = 3'd0,
    MT_EXACT    = 3'd1,
    MT_IND_HASH = 3'd2,
    MT_GRP_HASH = 3'd3,
    MT_BCAST    = 3'd4,
    MT_PROMISC  = 3'd5
  } match_e;

  typedef enum logic [1:0] {
    FM_INDIV   = 2'd0,
    FM_LOGICAL = 2'd1,
    FM_PROMISC = 2'd2,
    FM_DROP    = 2'd3
  } fmode_e;

  // One byte of the reflected CRC-32 update, least significant bit first.
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] crc_in,
                                                     input logic [BYTE_W-1:0] data);
    logic [CRC_W-1:0] r;
    r = crc_in;
    for (int b = 0; b < BYTE_W; b++) begin
      if (r[0] ^ data[b]) r = (r >> 1) ^ CRC_POLY_REFL;
      else                r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_af_collect.sv
module eth_af_collect
  import eth_af_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         byte_valid,
  input  logic                         byte_sof,
  input  logic [BYTE_W-1:0]            byte_data,
  input  logic                         frame_end,
  output logic [BYTE_W*ADDR_BYTES-1:0] addr_now,
  output logic [CRC_W-1:0]             crc_now,
  output logic                         addr_last
);

  localparam int ADDR_W = BYTE_W * ADDR_BYTES;
  localparam int CNT_W  = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  slot;
  logic              take;
  logic [ADDR_W-1:0] addr_q;
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  crc_base;

  always_comb begin
    slot     = byte_sof ? '0 : cnt_q;
    take     = byte_valid && (slot < CNT_DONE);
    crc_base = byte_sof ? '1 : crc_q;
    crc_now  = take ? crc_step_byte(crc_base, byte_data) : crc_q;
    addr_last = take && (slot == CNT_LAST);
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
    assign addr_now[g*BYTE_W +: BYTE_W] =
      (take && (slot == CNT_W'(g))) ? byte_data : addr_q[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_DONE;
      addr_q <= '0;
      crc_q  <= '1;
    end else if (frame_end) begin
      cnt_q  <= CNT_DONE;
    end else if (take) begin
      cnt_q  <= slot + CNT_W'(1);
      addr_q <= addr_now;
      crc_q  <= crc_now;
    end
  end

endmodule

// File: rtl/eth_af_classify.sv
module eth_af_classify
  import eth_af_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic [BYTE_W*ADDR_BYTES-1:0] addr,
  input  logic [CRC_W-1:0]             crc,
  input  logic [1:0]                   mode,
  input  logic                         ind_use_hash,
  input  logic                         bcast_en,
  input  logic [BYTE_W*ADDR_BYTES-1:0] station_addr,
  input  logic [(1<<HASH_BITS)-1:0]    ind_hash,
  input  logic [(1<<HASH_BITS)-1:0]    grp_hash,
  output logic                         is_group,
  output logic                         is_bcast,
  output logic [HASH_BITS-1:0]         bin_idx,
  output match_e                       mtype
);

  match_e indiv_type;

  always_comb begin
    is_group = addr[0];
    is_bcast = &addr;
    bin_idx  = crc[CRC_W-1 -: HASH_BITS];

    if (ind_use_hash)
      indiv_type = ind_hash[bin_idx] ? MT_IND_HASH : MT_NONE;
    else
      indiv_type = (addr == station_addr) ? MT_EXACT : MT_NONE;

    mtype = MT_NONE;
    unique case (fmode_e'(mode))
      FM_INDIV:   mtype = is_group ? MT_NONE : indiv_type;
      FM_LOGICAL: begin
        if (!is_group)     mtype = indiv_type;
        else if (is_bcast) mtype = bcast_en ? MT_BCAST : MT_NONE;
        else               mtype = grp_hash[bin_idx] ? MT_GRP_HASH : MT_NONE;
      end
      FM_PROMISC: mtype = MT_PROMISC;
      FM_DROP:    mtype = MT_NONE;
      default:    mtype = MT_NONE;
    endcase
  end

endmodule

// File: rtl/eth_af_verdict.sv
module eth_af_verdict
  import eth_af_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   addr_last,
  input  logic   byte_sof,
  input  logic   frame_end,
  input  logic   reject,
  input  match_e mtype_now,
  output logic   match_valid,
  output match_e mtype_q,
  output logic   have_addr,
  output logic   dec_valid,
  output logic   accept
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_valid <= 1'b0;
      mtype_q     <= MT_NONE;
      have_addr   <= 1'b0;
      dec_valid   <= 1'b0;
      accept      <= 1'b0;
    end else begin
      match_valid <= addr_last && !frame_end;
      dec_valid   <= frame_end;
      if (frame_end) begin
        accept    <= have_addr && (mtype_q != MT_NONE) && !reject;
        have_addr <= 1'b0;
      end else if (addr_last) begin
        mtype_q   <= mtype_now;
        have_addr <= 1'b1;
      end else if (byte_sof) begin
        have_addr <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import eth_af_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          byte_valid,
  input  logic                          byte_sof,
  input  logic [7:0]                    byte_data,
  input  logic                          frame_end,
  input  logic                          reject,
  input  logic [1:0]                    mode,
  input  logic                          ind_use_hash,
  input  logic                          bcast_en,
  input  logic [8*ADDR_BYTES-1:0]       station_addr,
  input  logic [(1<<HASH_BITS)-1:0]     ind_hash,
  input  logic [(1<<HASH_BITS)-1:0]     grp_hash,
  output logic                          match_valid,
  output logic [2:0]                    match_type,
  output logic                          dec_valid,
  output logic                          accept
);

  localparam int ADDR_W = BYTE_W * ADDR_BYTES;

  logic [ADDR_W-1:0]    addr_now;
  logic [CRC_W-1:0]     crc_now;
  logic                 addr_last;
  logic                 cls_is_group;
  logic                 cls_is_bcast;
  logic [HASH_BITS-1:0] cls_bin;
  match_e               cls_type;
  match_e               held_type;
  logic                 have_addr;

  eth_af_collect #(.ADDR_BYTES(ADDR_BYTES)) u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .byte_sof   (byte_sof),
    .byte_data  (byte_data),
    .frame_end  (frame_end),
    .addr_now   (addr_now),
    .crc_now    (crc_now),
    .addr_last  (addr_last)
  );

  eth_af_classify #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_classify (
    .addr         (addr_now),
    .crc          (crc_now),
    .mode         (mode),
    .ind_use_hash (ind_use_hash),
    .bcast_en     (bcast_en),
    .station_addr (station_addr),
    .ind_hash     (ind_hash),
    .grp_hash     (grp_hash),
    .is_group     (cls_is_group),
    .is_bcast     (cls_is_bcast),
    .bin_idx      (cls_bin),
    .mtype        (cls_type)
  );

  eth_af_verdict u_verdict (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_last   (addr_last),
    .byte_sof    (byte_sof),
    .frame_end   (frame_end),
    .reject      (reject),
    .mtype_now   (cls_type),
    .match_valid (match_valid),
    .mtype_q     (held_type),
    .have_addr   (have_addr),
    .dec_valid   (dec_valid),
    .accept      (accept)
  );

  assign match_type = held_type;

endmodule

// File: rtl/eth_af_checker.sv
module eth_af_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_end,
  input logic       reject,
  input logic [1:0] mode,
  input logic       addr_last,
  input logic       cls_is_group,
  input logic       match_valid,
  input logic [2:0] match_type,
  input logic       dec_valid,
  input logic       accept
);

  // R2: the match indication lasts exactly one cycle
  a_r2_match_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |=> !match_valid);

  // R2: the indication follows the last address byte by one cycle
  a_r2_match_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_last && !frame_end) |=> match_valid);

  // R5: group addresses never get an individual-rule code
  a_r5_group_not_indiv: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_last && !frame_end && cls_is_group) |=> (match_type != 3'd1 && match_type != 3'd2));

  // R9: promiscuous mode always reports code 5
  a_r9_promisc_code: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_last && !frame_end && mode == 2'd2) |=> (match_type == 3'd5));

  // R10: the verdict follows frame end by one cycle and only then
  a_r10_verdict_timing: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> dec_valid);
  a_r10_no_spurious_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> !dec_valid);

  // R10: the external veto forces a discard
  a_r10_reject_discards: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && reject) |=> !accept);

  // R3: a kept frame carries a real match code
  a_r3_keep_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && accept) |-> (match_type != 3'd0));

endmodule

bind eth_rx_addr_filter eth_af_checker u_af_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_end    (frame_end),
  .reject       (reject),
  .mode         (mode),
  .addr_last    (addr_last),
  .cls_is_group (cls_is_group),
  .match_valid  (match_valid),
  .match_type   (match_type),
  .dec_valid    (dec_valid),
  .accept       (accept)
);

// File: tb/tb_eth_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_eth_rx_addr_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0, byte_sof = 1'b0, frame_end = 1'b0, reject = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic [1:0]  mode = 2'd0;
  logic        ind_use_hash = 1'b0, bcast_en = 1'b0;
  logic [47:0] station_addr = 48'h0;
  logic [63:0] ind_hash = 64'h0, grp_hash = 64'h0;
  logic        match_valid, dec_valid, accept;
  logic [2:0]  match_type;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  eth_rx_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_sof(byte_sof),
    .byte_data(byte_data), .frame_end(frame_end), .reject(reject), .mode(mode),
    .ind_use_hash(ind_use_hash), .bcast_en(bcast_en), .station_addr(station_addr),
    .ind_hash(ind_hash), .grp_hash(grp_hash), .match_valid(match_valid),
    .match_type(match_type), .dec_valid(dec_valid), .accept(accept)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R7 restated: normal-form CRC shifting left, address bits fed LSB of byte 0 first,
  // then the reflected register's top six bits are the low six bits reversed.
  function automatic logic [5:0] bin_of(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [5:0]  r;
    for (int b = 0; b < 48; b++) begin
      logic fb;
      fb = c[31] ^ a[b];
      c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
    end
    for (int k = 0; k < 6; k++) r[k] = c[5-k];
    return r;
  endfunction

  // Sends a full address, one payload byte, then frame end; checks code and verdict.
  task automatic run_frame(input logic [47:0] a, input bit rej, input logic [2:0] exp_type,
                           input bit exp_acc, input string tag);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      byte_valid = 1'b1; byte_sof = (i == 0); byte_data = a[8*i +: 8];
      if (i > 0) check(match_valid == 1'b0, {tag, " R2 early"}, match_valid, 0);
    end
    @(negedge clk);
    byte_valid = 1'b1; byte_sof = 1'b0; byte_data = ~a[7:0];
    check(match_valid == 1'b1, {tag, " R2 pulse"}, match_valid, 1);
    check(match_type == exp_type, {tag, " code"}, match_type, exp_type);
    @(negedge clk);
    byte_valid = 1'b0;
    check(match_valid == 1'b0, {tag, " R2 one cycle"}, match_valid, 0);
    frame_end = 1'b1; reject = rej;
    @(negedge clk);
    frame_end = 1'b0; reject = 1'b0;
    check(dec_valid == 1'b1, {tag, " R10 dec_valid"}, dec_valid, 1);
    check(accept == exp_acc, {tag, " R10 accept"}, accept, exp_acc);
    check(match_type == exp_type, {tag, " R3 held after payload"}, match_type, exp_type);
    @(negedge clk);
    check(dec_valid == 1'b0, {tag, " R10 dec pulse"}, dec_valid, 0);
  endtask

  task automatic t_reset();
    check(match_valid == 0 && dec_valid == 0 && accept == 0 && match_type == 0,
          "R1 reset state", {match_valid, dec_valid, accept, match_type}, 0);
  endtask

  task automatic t_exact();
    mode = 2'd0; ind_use_hash = 0; station_addr = 48'h6655_4433_2210;
    run_frame(48'h6655_4433_2210, 0, 3'd1, 1, "R5 exact hit");
    run_frame(48'h6655_4433_2290, 0, 3'd0, 0, "R5 exact miss");
    run_frame(48'h6655_4433_2211, 0, 3'd0, 0, "R4 R5 group in indiv mode");
    run_frame(48'hFFFF_FFFF_FFFF, 0, 3'd0, 0, "R5 bcast in indiv mode");
    run_frame(48'h6655_4433_2210, 1, 3'd1, 0, "R10 reject on exact hit");
  endtask

  task automatic t_ind_hash();
    logic [47:0] a = 48'h1234_5678_9A02;
    mode = 2'd0; ind_use_hash = 1;
    ind_hash = 64'h1 << bin_of(a);
    run_frame(a, 0, 3'd2, 1, "R6 R7 ind bin set");
    ind_hash = ~(64'h1 << bin_of(a));
    run_frame(a, 0, 3'd0, 0, "R6 R7 ind bin clear");
    ind_use_hash = 0;
  endtask

  task automatic t_logical();
    logic [47:0] g = 48'h0B00_005E_0001;
    mode = 2'd1; bcast_en = 1;
    grp_hash = 64'h1 << bin_of(g);
    run_frame(g, 0, 3'd3, 1, "R8 group bin set");
    grp_hash = ~(64'h1 << bin_of(g));
    run_frame(g, 0, 3'd0, 0, "R8 group bin clear");
    grp_hash = 64'h0;
    run_frame(48'hFFFF_FFFF_FFFF, 0, 3'd4, 1, "R8 bcast enabled");
    bcast_en = 0; grp_hash = '1;
    run_frame(48'hFFFF_FFFF_FFFF, 0, 3'd0, 0, "R8 bcast disabled");
    station_addr = 48'hA1B2_C3D4_E5F6;
    run_frame(48'hA1B2_C3D4_E5F6, 0, 3'd1, 1, "R8 indiv in logical");
    grp_hash = 64'h0;
  endtask

  task automatic t_promisc();
    mode = 2'd2;
    run_frame(48'h0102_0304_0506, 0, 3'd5, 1, "R9 promisc indiv");
    run_frame(48'h0102_0304_0507, 1, 3'd5, 0, "R9 R10 promisc reject");
    mode = 2'd3;
    run_frame(48'h6655_4433_2210, 0, 3'd0, 0, "R9 drop-all mode");
  endtask

  task automatic t_runt();
    mode = 2'd2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      byte_valid = 1; byte_sof = (i == 0); byte_data = 8'h40 + 8'(i);
    end
    @(negedge clk);
    byte_valid = 0; byte_sof = 0; frame_end = 1;
    @(negedge clk);
    frame_end = 0;
    check(dec_valid == 1 && accept == 0, "R11 runt discarded", accept, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      byte_valid = 1; byte_sof = 0; byte_data = 8'h70 + 8'(i);
      check(match_valid == 0, "R11 R2 no match for runt", match_valid, 0);
    end
    @(negedge clk);
    byte_valid = 0;
    check(match_valid == 0, "R2 bytes without sof ignored", match_valid, 0);
    @(negedge clk);
    frame_end = 1;
    @(negedge clk);
    frame_end = 0;
    check(dec_valid == 1 && accept == 0, "R2 R11 no sof frame discarded", accept, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_ind_hash();
    t_logical();
    t_promisc();
    t_runt();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule